// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block divides one source clock into two bank clocks, A and C, each at a selectable even ratio of the source. It also raises a marker pulse whenever the two banks produce a rising edge on the same source edge. When the two bank frequencies stand in a non-binary ratio such as 3:2 or 4:3, that shared edge recurs only once per common period, and downstream logic can use the pulse as its reference point for phase alignment.

A single counter advances at the source rate and wraps at the least common multiple of the two ratios. Its zero position is the shared rising edge. The pulse stays high for one full period of the faster bank. A fourth output, D, carries either the marker pulse or a copy of bank C, chosen by a steering input, so the same pins can also serve as extra bank-C outputs.

The ratio codes are captured on the first source edge after reset is released. All counters start together on that edge. A new ratio therefore takes effect only after another reset.

Top module: `sync_pulse_gen`

## Requirements
- R1: While rst_n is low, bank_a, bank_c, bank_d and sync_pulse are all 0, for either value of sync_sel.
- R2: A ratio code selects the bank period in source cycles: code 0 gives 2, code 1 gives 4, code 2 gives 6 and code 3 gives 8.
- R3: Each bank output is high for the first half of its period and low for the second half. Both banks begin a high half on the first source edge after reset release. Outputs change only on source edges.
- R4: sync_pulse is high for exactly min(NA, NC) source cycles, starting on every edge where both banks rise together. It repeats every lcm(NA, NC) source cycles and is low at all other times.
- R5: The first sync pulse begins on the first source edge after rst_n is released.
- R6: When both ratio codes are equal, sync_pulse stays high on every source cycle after reset release.
- R7: bank_d equals sync_pulse when sync_sel is 0 and equals bank_c when sync_sel is 1. It follows a change of sync_sel with no clock delay.
- R8: The ratio codes are captured on the first source edge after reset release. Changing them later has no effect on any output until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| ratio_a_code | input | 2 | Ratio code for bank A |
| ratio_c_code | input | 2 | Ratio code for bank C |
| sync_sel | input | 1 | 0: bank_d carries sync_pulse; 1: bank_d copies bank_c |
| bank_a | output | 1 | Divided bank A clock |
| bank_c | output | 1 | Divided bank C clock |
| bank_d | output | 1 | Steered output, sync pulse or bank C copy |
| sync_pulse | output | 1 | Coincident rising edge marker |

## Verification
Directed runs cover four ratio pairs:
- The 3:2 and 4:3 pairs give periods of 12 and 24, which checks that the counter wraps at the least common multiple and not at the product or the larger ratio.
- Equal ratios show that the pulse stays high.
- The 2:8 pair and its mirror show that the pulse width follows the faster bank, whichever bank that is.

Random runs draw codes and the steering input every cycle, which checks that bank_d switches without delay. Some runs scramble the ratio inputs after start, which shows that the captured codes hold until the next reset.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

    localparam int CODE_W    = 2;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int MAX_RATIO = 2 * NUM_CODES;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    typedef logic [CODE_W-1:0] code_t;

    // Even divide ratio selected by a code: 2, 4, 6, ...
    function automatic int ratio_of(input int code);
        return 2 * (code + 1);
    endfunction

    // Smallest common multiple of a and b (b never exceeds MAX_RATIO)
    function automatic int lcm_of(input int a, input int b);
        int r;
        r = a * b;
        for (int k = MAX_RATIO; k >= 1; k--) begin
            if (((a * k) % b) == 0) r = a * k;
        end
        return r;
    endfunction

    function automatic int max_period();
        int m;
        m = 1;
        for (int i = 0; i < NUM_CODES; i++) begin
            for (int j = 0; j < NUM_CODES; j++) begin
                if (lcm_of(ratio_of(i), ratio_of(j)) > m)
                    m = lcm_of(ratio_of(i), ratio_of(j));
            end
        end
        return m;
    endfunction

    localparam int MAX_PERIOD = max_period();
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

    typedef struct packed {
        logic  started;
        code_t code_a;
        code_t code_c;
    } cfg_t;

endpackage

// File: rtl/sync_bank_div.sv
module sync_bank_div
    import sync_gen_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  code_t code,
    output logic  level_q
);

    typedef struct packed {
        logic [RATIO_W-1:0] phase;
        logic               level;
    } div_t;

    div_t               st_d, st_q;
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] half;
    logic [RATIO_W-1:0] phase_inc;

    always_comb begin
        ratio     = RATIO_W'(ratio_of(int'(code)));
        half      = ratio >> 1;
        phase_inc = st_q.phase + RATIO_W'(1);
        st_d      = st_q;
        if (restart) begin
            st_d.phase = '0;
        end else if (phase_inc >= ratio) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = phase_inc;
        end
        st_d.level = (st_d.phase < half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_q = st_q.level;

endmodule

// File: rtl/sync_period_ctr.sv
module sync_period_ctr
    import sync_gen_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  code_t code_a,
    input  code_t code_c,
    output logic  pulse_q
);

    localparam int TBL_N = NUM_CODES * NUM_CODES;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } per_t;

    per_t             st_d, st_q;
    logic [CNT_W-1:0] period_tbl [TBL_N];
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] ra, rc, span;
    logic [CNT_W-1:0] cnt_inc;

    // Common period for every code pair, computed at elaboration
    for (genvar ga = 0; ga < NUM_CODES; ga++) begin : g_row
        for (genvar gc = 0; gc < NUM_CODES; gc++) begin : g_col
            localparam int PV = lcm_of(ratio_of(ga), ratio_of(gc));
            assign period_tbl[ga*NUM_CODES + gc] = CNT_W'(PV);
        end
    end

    always_comb begin
        period  = period_tbl[{code_a, code_c}];
        ra      = CNT_W'(ratio_of(int'(code_a)));
        rc      = CNT_W'(ratio_of(int'(code_c)));
        span    = (ra < rc) ? ra : rc;
        cnt_inc = st_q.cnt + CNT_W'(1);
        st_d    = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (cnt_inc >= period) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_inc;
        end
        st_d.pulse = (st_d.cnt < span);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_q = st_q.pulse;

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
    import sync_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_a_code,
    input  logic [CODE_W-1:0] ratio_c_code,
    input  logic              sync_sel,
    output logic              bank_a,
    output logic              bank_c,
    output logic              bank_d,
    output logic              sync_pulse
);

    localparam int NUM_BANKS = 2;

    cfg_t  cfg_d, cfg_q;
    logic  started;
    code_t held_a, held_c;
    code_t eff_a, eff_c;
    code_t bank_code [NUM_BANKS];
    logic  bank_lvl  [NUM_BANKS];

    // Capture the ratio codes once, on the first edge after reset
    always_comb begin
        cfg_d = cfg_q;
        if (!cfg_q.started) begin
            cfg_d.started = 1'b1;
            cfg_d.code_a  = ratio_a_code;
            cfg_d.code_c  = ratio_c_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign started = cfg_q.started;
    assign held_a  = cfg_q.code_a;
    assign held_c  = cfg_q.code_c;
    assign eff_a   = started ? held_a : ratio_a_code;
    assign eff_c   = started ? held_c : ratio_c_code;

    assign bank_code[0] = eff_a;
    assign bank_code[1] = eff_c;

    for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
        sync_bank_div u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (!started),
            .code    (bank_code[gb]),
            .level_q (bank_lvl[gb])
        );
    end

    sync_period_ctr u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (!started),
        .code_a  (eff_a),
        .code_c  (eff_c),
        .pulse_q (sync_pulse)
    );

    assign bank_a = bank_lvl[0];
    assign bank_c = bank_lvl[1];
    assign bank_d = sync_sel ? bank_c : sync_pulse;

endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk
    import sync_gen_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  bank_a,
    input logic  bank_c,
    input logic  bank_d,
    input logic  sync_pulse,
    input logic  started,
    input code_t held_a,
    input code_t held_c
);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (!bank_a && !bank_c && !bank_d && !sync_pulse);
        end
    end

    assert_coincident_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bank_a) && $rose(bank_c)) |-> sync_pulse);

    assert_pulse_on_high_banks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_pulse) |-> (bank_a && bank_c));

    assert_equal_ratio_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (started && (held_a == held_c)) |-> sync_pulse);

    assert_codes_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        started |=> (started && $stable(held_a) && $stable(held_c)));

endmodule

bind sync_pulse_gen sync_pulse_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_a     (bank_a),
    .bank_c     (bank_c),
    .bank_d     (bank_d),
    .sync_pulse (sync_pulse),
    .started    (started),
    .held_a     (held_a),
    .held_c     (held_c)
);

// File: tb/tb_sync_pulse_gen.sv
module tb_sync_pulse_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sync_sel;
    logic [1:0] ra, rc;
    logic       bank_a, bank_c, bank_d, sync_pulse;

    int vectors = 0;
    int misses  = 0;
    int t       = 0;
    int exp_a   = 0;
    int exp_c   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    sync_pulse_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ratio_a_code (ra),
        .ratio_c_code (rc),
        .sync_sel     (sync_sel),
        .bank_a       (bank_a),
        .bank_c       (bank_c),
        .bank_d       (bank_d),
        .sync_pulse   (sync_pulse)
    );

    function automatic int rat(input int code);
        return 2 * code + 2;
    endfunction

    function automatic int lcm_b(input int a, input int b);
        int m;
        m = a;
        while ((m % b) != 0) m += a;
        return m;
    endfunction

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s t=%0d actual=%b expected=%b", req, nm, t, act, exp);
        end
    endtask

    // R1: reset clears all outputs whatever the steering input
    task automatic reset_to(input int a, input int c);
        @(negedge clk);
        rst_n    = 1'b0;
        ra       = 2'(a);
        rc       = 2'(c);
        sync_sel = 1'($urandom % 2);
        @(negedge clk);
        #1;
        chk("R1", "bank_a", bank_a, 1'b0);
        chk("R1", "bank_c", bank_c, 1'b0);
        chk("R1", "bank_d", bank_d, 1'b0);
        chk("R1", "sync_pulse", sync_pulse, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_a = a;
        exp_c = c;
        t     = 0;
    endtask

    task automatic run(input int n, input bit scramble);
        int    na, nc, per, span;
        logic  xa, xc, xs;
        string ta, tc, ts;
        na   = rat(exp_a);
        nc   = rat(exp_c);
        per  = lcm_b(na, nc);
        span = (na < nc) ? na : nc;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sync_sel = 1'($urandom % 2);
            if (scramble) begin
                ra = 2'($urandom % 4);
                rc = 2'($urandom % 4);
            end
            #1;
            xa = ((t % na) < (na / 2));
            xc = ((t % nc) < (nc / 2));
            xs = ((t % per) < span);
            ta = scramble ? "R8" : "R3";
            tc = scramble ? "R8" : "R2";
            if (t == 0)        ts = "R5";
            else if (na == nc) ts = "R6";
            else               ts = "R4";
            chk(ta, "bank_a", bank_a, xa);
            chk(tc, "bank_c", bank_c, xc);
            chk(ts, "sync_pulse", sync_pulse, xs);
            chk("R7", "bank_d", bank_d, sync_sel ? xc : xs);
            t++;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        rst_n    = 1'b0;
        sync_sel = 1'b0;
        ra       = 2'd0;
        rc       = 2'd0;
        void'($urandom(32'd991));
        // 3:2 relation, period 12
        reset_to(2, 1); run(30, 1'b0);
        // 4:3 relation, period 24
        reset_to(3, 2); run(60, 1'b0);
        // equal ratios keep the pulse high
        reset_to(1, 1); run(20, 1'b0);
        // bank A fastest, then bank C fastest
        reset_to(0, 3); run(24, 1'b0);
        reset_to(3, 0); run(24, 1'b0);
        // inputs scrambled after start are ignored
        reset_to(2, 1); run(40, 1'b1);
        for (int k = 0; k < 24; k++) begin
            int a, c;
            a = int'($urandom % 4);
            c = int'($urandom % 4);
            reset_to(a, c);
            run(30 + int'($urandom % 40), (k % 4) == 3);
        end
        reset_to(0, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule